// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits between a processor's in-order stream of memory operations and a memory system that may finish those operations in any order. Each incoming operation carries a kind: a plain data access, a fence, an acquire or a release. The gate decides in which cycle each one may leave for memory. It stalls the stream only as far as the ordering rule for that kind of operation requires.

One up/down counter tracks how many data accesses have been issued but not yet completed. Fences and releases are held until that count reaches zero. Acquires leave at once, but nothing behind an acquire may pass until the acquire's own completion pulse has returned. Releases do not hold back the accesses that follow them. Two single-bit flags record an acquire and a release that are still in flight. Plain data accesses issue one per cycle whenever no acquire is in flight.

Top module: `ord_gate`

## Requirements
- R1: With no acquire in flight, a data operation (kind code 2'b00) is accepted in the cycle it is presented. It appears on the issue output in that same cycle with kind 2'b00, so consecutive data operations issue one per cycle.
- R2: The outstanding count goes up by one for each data operation issued and down by one for each completion tagged 2'b00. When an issue and a data completion fall in the same cycle, the count does not change. A completion tagged 2'b01 changes nothing.
- R3: A fence (kind code 2'b01) is accepted only in a cycle when the registered outstanding count is zero. A completion that arrives in the same cycle does not count until the next cycle. A fence is never placed on the issue output.
- R4: An acquire (kind code 2'b10) is issued in the cycle it is presented whenever no other acquire is in flight, even while data operations are outstanding.
- R5: After an acquire issues, no operation of any kind is accepted until a completion tagged 2'b10 arrives. Acceptance resumes in the following cycle, and data completions alone do not lift the stall.
- R6: A release (kind code 2'b11) is issued only when the outstanding count is zero and no earlier release is still awaiting its completion, which is tagged 2'b11.
- R7: While a release is awaiting completion, later data operations and acquires are accepted without delay.
- R8: An issue at the count's maximum leaves the count at its maximum. A data completion at zero leaves the count at zero. Either event sets an error flag, which stays set until reset.
- R9: After reset the count is zero, no acquire or release is in flight, the error flag is low and a presented data operation is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Incoming operation present |
| op_kind | input | 2 | 00 data, 01 fence, 10 acquire, 11 release |
| op_ready | output | 1 | Operation accepted this cycle |
| mem_valid | output | 1 | Operation sent to memory this cycle |
| mem_kind | output | 2 | Kind of the operation sent (never 01) |
| done_valid | input | 1 | One pulse per finished memory operation |
| done_tag | input | 2 | Kind of the finished operation: 00 data, 10 acquire, 11 release |
| ovf_err | output | 1 | Sticky count overflow/underflow flag |

## Verification
The bench builds the gate with a 3-bit counter instead of the default 4 bits. This lowers the saturation point to seven outstanding accesses, so a short burst of eight reaches it. With the same setting, the bench can show that after saturation a fence opens after exactly seven completions and not after a wrapped count. Every other rule is exercised with no more than four accesses in flight, so the smaller width takes nothing out of reach.

// File: rtl/ord_gate_pkg.sv
package ord_gate_pkg;

   typedef enum logic [1:0] {
      K_DATA  = 2'b00,
      K_FENCE = 2'b01,
      K_ACQ   = 2'b10,
      K_REL   = 2'b11
   } op_kind_e;

   localparam int unsigned N_SYNC = 2;   // index 0: acquire, 1: release

   function automatic logic [1:0] sync_code(input int unsigned idx);
      return (idx == 0) ? 2'(K_ACQ) : 2'(K_REL);
   endfunction

endpackage

// File: rtl/ord_outstanding.sv
module ord_outstanding #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             down,
   output logic [CNT_W-1:0] cnt,
   output logic             is_zero,
   output logic             err
);
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CNT_ZERO;
         err <= 1'b0;
      end else begin
         unique case ({up, down})
            2'b10: begin
               if (cnt == CNT_MAX) err <= 1'b1;
               else                cnt <= cnt + CNT_ONE;
            end
            2'b01: begin
               if (cnt == CNT_ZERO) err <= 1'b1;
               else                 cnt <= cnt - CNT_ONE;
            end
            default: ;
         endcase
      end
   end

   assign is_zero = (cnt == CNT_ZERO);

   assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!up && down && cnt != CNT_ZERO) |=> (cnt == $past(cnt) - CNT_ONE));
   assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up == down) |=> $stable(cnt));
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (up && !down && cnt == CNT_MAX) |=> (cnt == CNT_MAX && err));
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!up && down && cnt == CNT_ZERO) |=> (cnt == CNT_ZERO && err));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

// File: rtl/ord_sync_flag.sv
module ord_sync_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   assert_set_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set |-> !pend);
   assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);

endmodule

// File: rtl/ord_issue_ctl.sv
module ord_issue_ctl
   import ord_gate_pkg::*;
(
   input  logic       op_valid,
   input  logic [1:0] op_kind,
   input  logic       cnt_zero,
   input  logic       acq_pend,
   input  logic       rel_pend,
   output logic       op_ready,
   output logic       mem_valid,
   output logic [1:0] mem_kind,
   output logic       fire_data,
   output logic       fire_acq,
   output logic       fire_rel
);
   logic allow;
   logic take;

   always_comb begin
      unique case (op_kind_e'(op_kind))
         K_DATA:  allow = 1'b1;
         K_FENCE: allow = cnt_zero;
         K_ACQ:   allow = 1'b1;
         K_REL:   allow = cnt_zero && !rel_pend;
         default: allow = 1'b0;
      endcase
      op_ready = allow && !acq_pend;
   end

   assign take      = op_valid && op_ready;
   assign mem_valid = take && (op_kind != 2'(K_FENCE));
   assign mem_kind  = op_kind;
   assign fire_data = take && (op_kind == 2'(K_DATA));
   assign fire_acq  = take && (op_kind == 2'(K_ACQ));
   assign fire_rel  = take && (op_kind == 2'(K_REL));

endmodule

// File: rtl/ord_gate.sv
module ord_gate
   import ord_gate_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [1:0] op_kind,
   output logic       op_ready,
   output logic       mem_valid,
   output logic [1:0] mem_kind,
   input  logic       done_valid,
   input  logic [1:0] done_tag,
   output logic       ovf_err
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("ord_gate: CNT_W must lie in 2..16");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             fire_data, fire_acq, fire_rel;
   logic             done_data;
   logic [N_SYNC-1:0] sync_set, sync_clr, sync_pend;

   assign done_data = done_valid && (done_tag == 2'(K_DATA));

   ord_outstanding #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .up      (fire_data),
      .down    (done_data),
      .cnt     (cnt),
      .is_zero (cnt_zero),
      .err     (ovf_err)
   );

   assign sync_set = {fire_rel, fire_acq};

   for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
      assign sync_clr[g] = done_valid && (done_tag == sync_code(g));
      ord_sync_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (sync_set[g]),
         .clr   (sync_clr[g]),
         .pend  (sync_pend[g])
      );
   end

   ord_issue_ctl u_ctl (
      .op_valid  (op_valid),
      .op_kind   (op_kind),
      .cnt_zero  (cnt_zero),
      .acq_pend  (sync_pend[0]),
      .rel_pend  (sync_pend[1]),
      .op_ready  (op_ready),
      .mem_valid (mem_valid),
      .mem_kind  (mem_kind),
      .fire_data (fire_data),
      .fire_acq  (fire_acq),
      .fire_rel  (fire_rel)
   );

   assert_data_flows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == 2'(K_DATA) && !sync_pend[0]) |-> op_ready);
   assert_fence_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_kind == 2'(K_FENCE)) |-> (cnt == '0));
   assert_fence_not_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_kind != 2'(K_FENCE)));
   assert_acq_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'(K_ACQ) && !sync_pend[0]) |-> mem_valid);
   assert_acq_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pend[0] |-> (!op_ready && !mem_valid));
   assert_rel_ordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_kind == 2'(K_REL)) |-> (cnt == '0 && !sync_pend[1]));
   assert_rel_no_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pend[1] && !sync_pend[0] && op_valid && op_kind[0] == 1'b0) |-> mem_valid);

endmodule

// File: tb/ord_gate_tb.sv
module ord_gate_tb;
   localparam int unsigned CNT_W = 3;
   localparam logic [1:0] KD = 2'b00, KF = 2'b01, KA = 2'b10, KR = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [1:0] op_kind = KD;
   logic       op_ready;
   logic       mem_valid;
   logic [1:0] mem_kind;
   logic       done_valid = 1'b0;
   logic [1:0] done_tag = KD;
   logic       ovf_err;

   int checks = 0;
   int errors = 0;
   logic [1:0] exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   ord_gate #(.CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_ready(op_ready), .mem_valid(mem_valid), .mem_kind(mem_kind),
      .done_valid(done_valid), .done_tag(done_tag), .ovf_err(ovf_err));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: every issued operation must match the next expected kind
   always @(negedge clk) begin
      if (rst_n && mem_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1: actual=%0d expected=none (unexpected issue)", mem_kind);
         end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            if (mem_kind != e) begin
               errors++;
               $display("FAIL R1: actual=%0d expected=%0d (issued kind)", mem_kind, e);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic send(input logic [1:0] k, output int waits);
      waits = 0;
      if (k != KF) exp_q.push_back(k);
      op_valid = 1'b1; op_kind = k;
      @(negedge clk);
      while (!op_ready) begin waits++; @(negedge clk); end
      step();
      op_valid = 1'b0;
   endtask

   task automatic pulse(input logic [1:0] t);
      done_valid = 1'b1; done_tag = t;
      step();
      done_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; op_valid = 1'b0; done_valid = 1'b0; op_kind = KD;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int w;
      do_reset();
      // R9: reset state
      @(negedge clk);
      chk("R9 err low", ovf_err, 0);
      chk("R9 data ready", op_ready, 1);
      chk("R9 no issue", mem_valid, 0);
      step();

      // R1: back-to-back data
      for (int i = 0; i < 4; i++) begin
         send(KD, w);
         chk("R1 no stall", w, 0);
      end

      // R3: fence waits for four completions (count 4)
      op_valid = 1'b1; op_kind = KF;
      for (int i = 0; i < 4; i++) begin
         done_valid = 1'b1; done_tag = KD;
         @(negedge clk);
         chk("R3 fence held", op_ready, 0);
         step();
         done_valid = 1'b0;
      end
      @(negedge clk);
      chk("R3 fence ready at zero", op_ready, 1);
      chk("R3 fence not issued", mem_valid, 0);
      step();
      op_valid = 1'b0;

      // R2: same-cycle issue and completion, fence tag ignored
      send(KD, w);
      fork
         send(KD, w);
         pulse(KD);
      join
      op_valid = 1'b1; op_kind = KF;
      @(negedge clk);
      chk("R2 count one holds fence", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KF;
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R2 fence-tag completion ignored", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KD;
      @(negedge clk);
      chk("R3 same-cycle completion not counted", op_ready, 0);
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R2 count reached zero", op_ready, 1);
      step();
      op_valid = 1'b0;

      // R4/R5: acquire with data outstanding
      send(KD, w); send(KD, w);
      send(KA, w);
      chk("R4 acquire immediate", w, 0);
      exp_q.push_back(KD);
      op_valid = 1'b1; op_kind = KD;
      @(negedge clk);
      chk("R5 data held by acquire", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KD;
      @(negedge clk);
      chk("R5 held during data done", op_ready, 0);
      step();
      @(negedge clk);
      chk("R5 held after data done", op_ready, 0);
      step();
      done_tag = KA;
      @(negedge clk);
      chk("R5 held in acquire done cycle", op_ready, 0);
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R5 released after acquire done", op_ready, 1);
      chk("R5 data issued", mem_valid, 1);
      step();
      op_valid = 1'b0;

      // R6: release waits for count zero (count 1)
      exp_q.push_back(KR);
      op_valid = 1'b1; op_kind = KR;
      @(negedge clk);
      chk("R6 release held by count", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KD;
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R6 release at zero", op_ready, 1);
      step();
      op_valid = 1'b0;

      // R7: accesses pass a pending release
      send(KD, w);
      chk("R7 data past release", w, 0);
      send(KA, w);
      chk("R7 acquire past release", w, 0);
      pulse(KA);
      pulse(KD);
      // R6: second release waits for the first
      exp_q.push_back(KR);
      op_valid = 1'b1; op_kind = KR;
      @(negedge clk);
      chk("R6 release held by release", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KR;
      @(negedge clk);
      chk("R6 held in release done cycle", op_ready, 0);
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R6 second release issues", op_ready, 1);
      step();
      op_valid = 1'b0;
      pulse(KR);

      // R8: saturation at 7
      for (int i = 0; i < 7; i++) send(KD, w);
      @(negedge clk);
      chk("R8 no error at max", ovf_err, 0);
      step();
      send(KD, w);
      chk("R8 issue at max accepted", w, 0);
      @(negedge clk);
      chk("R8 overflow flagged", ovf_err, 1);
      step();
      for (int i = 0; i < 6; i++) pulse(KD);
      op_valid = 1'b1; op_kind = KF;
      @(negedge clk);
      chk("R8 saturated count held fence", op_ready, 0);
      step();
      done_valid = 1'b1; done_tag = KD;
      step();
      done_valid = 1'b0;
      @(negedge clk);
      chk("R8 fence after seven completions", op_ready, 1);
      chk("R8 error sticky", ovf_err, 1);
      step();
      op_valid = 1'b0;

      // R9: reset clears a pending acquire and the error
      send(KA, w);
      do_reset();
      op_kind = KD;
      @(negedge clk);
      chk("R9 error cleared", ovf_err, 0);
      chk("R9 acquire cleared", op_ready, 1);
      step();

      // R8: underflow
      pulse(KD);
      @(negedge clk);
      chk("R8 underflow flagged", ovf_err, 1);
      step();
      op_valid = 1'b1; op_kind = KF;
      @(negedge clk);
      chk("R8 count stayed zero", op_ready, 1);
      step();
      op_valid = 1'b0;

      repeat (2) step();
      chk("R1 all expected issues seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule